// File: doc/BRIEF.md
# SD Host Data Phase Controller

This block runs the data phase of an SD host transfer. Software writes a block count and block size, a pair of FIFO watermarks (one for reads, one for writes) and a data timeout exponent through a small register write port, then starts a transfer in either direction. The controller counts 32-bit words moved on the card side into blocks, and blocks into the transfer. It sets a sticky completion flag after the last word of the last block.

A level-only buffer model sits between the host side (push and pop strobes) and the card side (a one-word-per-strobe stream that stands in for the data lines). From its fill level the block raises buffer-read-ready and buffer-write-ready against the programmed watermarks. A data timeout counter advances on SD clock enables and restarts on every word the card side moves, so it measures only an idle gap. When it expires, the transfer is aborted and a timeout flag is set. A write is refused while the card reports write protection. A self-clearing data-reset control bit aborts the transfer.

Top module: `sdd_data_phase`

## Requirements
- R1: After reset, busy is 0, all status bits are 0, the buffer level is 0, the blocks-left count is 0, and the timeout exponent is 14.
- R2: The block register (address 0) holds the block count in bits 31:16 and the block size in bytes in bits 11:0. A block is size/4 words, with a minimum of one word. Blocks-left drops by one when the last word of a block is moved on the card side. After the last block, busy drops and status bit 0 (transfer complete) is set. A start with a block count of zero sets transfer complete and does not go busy.
- R3: The watermark register (address 1) holds the read watermark in bits 7:0 and the write watermark in bits 23:16, both counted in words. buf_rd_ready is 1 when the direction is read, the level is non-zero and the level is at least the read watermark. buf_wr_ready is 1 when a write is busy and the free space (DEPTH minus level) is at least the write watermark.
- R4: The control register is at address 2. Bit 0 starts a transfer, bit 1 selects read (1) or write (0), bit 2 is data reset, and bits 19:16 are the timeout exponent n. Status bit 1 (data timeout) is set exactly 2^(n+TMO_BASE) enabled SD clocks after the start, provided no word is moved in that time. The same edge ends busy.
- R5: Each word moved on the card side restarts the timeout count from zero.
- R6: A written exponent above 14 is stored as 14.
- R7: Starting a write while wp_locked is 1 sets status bit 2 (write refused) and leaves busy at 0. A read start is not affected by wp_locked.
- R8: Status (address 3) is write-one-to-clear: each 1 written clears that bit, and each 0 leaves it unchanged.
- R9: Writing control bit 2 aborts the transfer one cycle after the write. Busy, the level and blocks-left become 0, no status bit is set, and the reset bit clears itself after that one cycle.
- R10: In a read, card_ready is 0 when the level equals DEPTH, and a card word offered then is not counted. In a write, card_ready is 0 at level 0. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| wp_locked | input | 1 | Card write-protect sense, 1 = locked |
| sd_clk_en | input | 1 | One-cycle enable per SD clock |
| card_word | input | 1 | Card side offers or takes one word |
| host_push | input | 1 | Host writes one word into the buffer |
| host_pop | input | 1 | Host reads one word from the buffer |
| card_ready | output | 1 | Card-side word can move this cycle |
| busy | output | 1 | Transfer in progress |
| blocks_left | output | 16 | Blocks still to transfer |
| fifo_level | output | 5 | Words held in the buffer |
| buf_rd_ready | output | 1 | Read watermark reached |
| buf_wr_ready | output | 1 | Write space watermark reached |
| stat | output | 3 | Sticky flags: 0 complete, 1 timeout, 2 write refused |

## Verification
Reads of two two-word blocks show the word-to-block boundary and the read watermark crossing. A three-word write filled past its space watermark separates the free-space rule from the level rule, and completes on card-side takes. Timeout runs with no card words, at exponents 0, 3 and a clamped 15, fix the exact expiry edge and the clamp. A run with one word moved mid-gap shows the restart. A filled buffer, a protected write, a partial status clear and a mid-transfer data reset each isolate one of the gating rules.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam logic [1:0] ADDR_BLK  = 2'd0;
  localparam logic [1:0] ADDR_WM   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_RD  = 1;
  localparam int CTRL_RST = 2;
  localparam int EXP_LSB  = 16;
  localparam int EXP_W    = 4;
  localparam logic [EXP_W-1:0] EXP_MAX = 4'd14;

  localparam int ST_TC  = 0;
  localparam int ST_DTO = 1;
  localparam int ST_WPE = 2;
  localparam int ST_W   = 3;
endpackage

// File: rtl/sdd_regs.sv
module sdd_regs
  import sdd_pkg::*;
#(
  parameter int BLK_W  = 16,
  parameter int SIZE_W = 12,
  parameter int WM_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              set_tc,
  input  logic              set_dto,
  input  logic              set_wpe,
  output logic [BLK_W-1:0]  blk_cnt,
  output logic [SIZE_W-1:0] blk_size,
  output logic [WM_W-1:0]   rd_wm,
  output logic [WM_W-1:0]   wr_wm,
  output logic [EXP_W-1:0]  tmo_exp,
  output logic [ST_W-1:0]   stat,
  output logic              dreset,
  output logic              go,
  output logic              go_rd
);
  logic              wr_blk, wr_wm_reg, wr_ctrl, wr_stat;
  logic [BLK_W-1:0]  blk_cnt_nx;
  logic [SIZE_W-1:0] blk_size_nx;
  logic [WM_W-1:0]   rd_wm_nx, wr_wm_nx;
  logic [EXP_W-1:0]  tmo_exp_nx, exp_in;
  logic [ST_W-1:0]   stat_nx, stat_clr;
  logic              dreset_nx;

  always_comb begin
    wr_blk    = cfg_wr && (cfg_addr == ADDR_BLK);
    wr_wm_reg = cfg_wr && (cfg_addr == ADDR_WM);
    wr_ctrl   = cfg_wr && (cfg_addr == ADDR_CTRL);
    wr_stat   = cfg_wr && (cfg_addr == ADDR_STAT);
    exp_in    = cfg_wdata[EXP_LSB +: EXP_W];

    blk_cnt_nx  = wr_blk ? cfg_wdata[16 +: BLK_W] : blk_cnt;
    blk_size_nx = wr_blk ? cfg_wdata[SIZE_W-1:0] : blk_size;
    rd_wm_nx    = wr_wm_reg ? cfg_wdata[WM_W-1:0] : rd_wm;
    wr_wm_nx    = wr_wm_reg ? cfg_wdata[16 +: WM_W] : wr_wm;
    tmo_exp_nx  = tmo_exp;
    if (wr_ctrl) tmo_exp_nx = (exp_in > EXP_MAX) ? EXP_MAX : exp_in;

    dreset_nx = wr_ctrl && cfg_wdata[CTRL_RST];
    go        = wr_ctrl && cfg_wdata[CTRL_GO] && !cfg_wdata[CTRL_RST];
    go_rd     = cfg_wdata[CTRL_RD];

    stat_clr = wr_stat ? cfg_wdata[ST_W-1:0] : '0;
    stat_nx  = (stat & ~stat_clr);
    stat_nx[ST_TC]  = stat_nx[ST_TC]  | set_tc;
    stat_nx[ST_DTO] = stat_nx[ST_DTO] | set_dto;
    stat_nx[ST_WPE] = stat_nx[ST_WPE] | set_wpe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt  <= '0;
      blk_size <= '0;
      rd_wm    <= '0;
      wr_wm    <= '0;
      tmo_exp  <= EXP_MAX;
      stat     <= '0;
      dreset   <= 1'b0;
    end else begin
      blk_cnt  <= blk_cnt_nx;
      blk_size <= blk_size_nx;
      rd_wm    <= rd_wm_nx;
      wr_wm    <= wr_wm_nx;
      tmo_exp  <= tmo_exp_nx;
      stat     <= stat_nx;
      dreset   <= dreset_nx;
    end
  end
endmodule

// File: rtl/sdd_timeout.sv
module sdd_timeout
  import sdd_pkg::*;
#(
  parameter int TMO_BASE = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             restart,
  input  logic             sd_clk_en,
  input  logic [EXP_W-1:0] tmo_exp,
  output logic             expire
);
  localparam int CNT_W = int'(EXP_MAX) + TMO_BASE + 1;

  logic [CNT_W-1:0] cnt, cnt_nx, lim;
  logic             at_lim;

  always_comb begin
    lim    = (CNT_W'(1) << (int'(tmo_exp) + TMO_BASE)) - CNT_W'(1);
    at_lim = (cnt == lim);
    expire = busy && !restart && sd_clk_en && at_lim;
    cnt_nx = cnt;
    if (restart || !busy)  cnt_nx = '0;
    else if (sd_clk_en)    cnt_nx = at_lim ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/sdd_xfer.sv
module sdd_xfer
#(
  parameter int DEPTH  = 16,
  parameter int BLK_W  = 16,
  parameter int SIZE_W = 12,
  parameter int WM_W   = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [BLK_W-1:0]  blk_cnt,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic [WM_W-1:0]   rd_wm,
  input  logic [WM_W-1:0]   wr_wm,
  input  logic              dreset,
  input  logic              wp_locked,
  input  logic              card_word,
  input  logic              host_push,
  input  logic              host_pop,
  input  logic              tmo_expire,
  output logic              busy,
  output logic [BLK_W-1:0]  blocks_left,
  output logic [LVL_W-1:0]  level,
  output logic              card_ready,
  output logic              buf_rd_ready,
  output logic              buf_wr_ready,
  output logic              start_ok,
  output logic              word_moved,
  output logic              set_tc,
  output logic              set_wpe
);
  localparam int WPB_W = SIZE_W - 2;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic             is_rd, is_rd_nx, busy_nx;
  logic [BLK_W-1:0] blocks_nx;
  logic [WPB_W-1:0] wcnt, wcnt_nx, wpb;
  logic [LVL_W-1:0] level_nx;
  logic             lvl_in, lvl_out, blk_end;
  logic [31:0]      lvl32, free32;

  always_comb begin
    wpb    = (blk_size[SIZE_W-1:2] == '0) ? WPB_W'(1) : blk_size[SIZE_W-1:2];
    lvl32  = 32'(level);
    free32 = 32'(FULL - level);

    card_ready   = busy && (is_rd ? (level != FULL) : (level != '0));
    word_moved   = card_ready && card_word;
    buf_rd_ready = is_rd && (level != '0) && (lvl32 >= 32'(rd_wm));
    buf_wr_ready = busy && !is_rd && (free32 >= 32'(wr_wm));

    if (is_rd) begin
      lvl_in  = word_moved;
      lvl_out = host_pop && (level != '0);
    end else begin
      lvl_in  = busy && host_push && (level != FULL);
      lvl_out = word_moved;
    end

    blk_end  = word_moved && (wcnt == wpb - WPB_W'(1));
    start_ok = go && !busy && !dreset && !(wp_locked && !go_rd) && (blk_cnt != '0);
    set_wpe  = go && !busy && !dreset && wp_locked && !go_rd;
    set_tc   = (go && !busy && !dreset && !(wp_locked && !go_rd) && (blk_cnt == '0))
             || (busy && !dreset && blk_end && (blocks_left == BLK_W'(1)));

    busy_nx   = busy;
    is_rd_nx  = is_rd;
    blocks_nx = blocks_left;
    wcnt_nx   = wcnt;
    level_nx  = level + LVL_W'(lvl_in) - LVL_W'(lvl_out);

    if (dreset) begin
      busy_nx   = 1'b0;
      blocks_nx = '0;
      wcnt_nx   = '0;
      level_nx  = '0;
    end else if (start_ok) begin
      busy_nx   = 1'b1;
      is_rd_nx  = go_rd;
      blocks_nx = blk_cnt;
      wcnt_nx   = '0;
      level_nx  = '0;
    end else if (busy) begin
      if (blk_end) begin
        wcnt_nx   = '0;
        blocks_nx = blocks_left - BLK_W'(1);
        if (blocks_left == BLK_W'(1)) busy_nx = 1'b0;
      end else if (word_moved) begin
        wcnt_nx = wcnt + WPB_W'(1);
      end
      if (tmo_expire) busy_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      is_rd       <= 1'b0;
      blocks_left <= '0;
      wcnt        <= '0;
      level       <= '0;
    end else begin
      busy        <= busy_nx;
      is_rd       <= is_rd_nx;
      blocks_left <= blocks_nx;
      wcnt        <= wcnt_nx;
      level       <= level_nx;
    end
  end
endmodule

// File: rtl/sdd_data_phase.sv
module sdd_data_phase
  import sdd_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TMO_BASE = 13,
  parameter int BLK_W    = 16,
  parameter int SIZE_W   = 12,
  parameter int WM_W     = 8,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              wp_locked,
  input  logic              sd_clk_en,
  input  logic              card_word,
  input  logic              host_push,
  input  logic              host_pop,
  output logic              card_ready,
  output logic              busy,
  output logic [BLK_W-1:0]  blocks_left,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              buf_rd_ready,
  output logic              buf_wr_ready,
  output logic [ST_W-1:0]   stat
);
  logic [BLK_W-1:0]  blk_cnt;
  logic [SIZE_W-1:0] blk_size;
  logic [WM_W-1:0]   rd_wm, wr_wm;
  logic [EXP_W-1:0]  tmo_exp;
  logic              dreset, go, go_rd;
  logic              set_tc, set_wpe, tmo_expire, start_ok, word_moved;

  sdd_regs #(.BLK_W(BLK_W), .SIZE_W(SIZE_W), .WM_W(WM_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .set_tc(set_tc), .set_dto(tmo_expire),
    .set_wpe(set_wpe), .blk_cnt(blk_cnt), .blk_size(blk_size),
    .rd_wm(rd_wm), .wr_wm(wr_wm), .tmo_exp(tmo_exp), .stat(stat),
    .dreset(dreset), .go(go), .go_rd(go_rd)
  );

  sdd_xfer #(.DEPTH(DEPTH), .BLK_W(BLK_W), .SIZE_W(SIZE_W), .WM_W(WM_W),
             .LVL_W(LVL_W)) xfer_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .blk_cnt(blk_cnt),
    .blk_size(blk_size), .rd_wm(rd_wm), .wr_wm(wr_wm), .dreset(dreset),
    .wp_locked(wp_locked), .card_word(card_word), .host_push(host_push),
    .host_pop(host_pop), .tmo_expire(tmo_expire), .busy(busy),
    .blocks_left(blocks_left), .level(fifo_level), .card_ready(card_ready),
    .buf_rd_ready(buf_rd_ready), .buf_wr_ready(buf_wr_ready),
    .start_ok(start_ok), .word_moved(word_moved), .set_tc(set_tc),
    .set_wpe(set_wpe)
  );

  sdd_timeout #(.TMO_BASE(TMO_BASE)) tmo_i (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .restart(start_ok || word_moved || dreset),
    .sd_clk_en(sd_clk_en), .tmo_exp(tmo_exp), .expire(tmo_expire)
  );
endmodule

// File: rtl/sdd_data_phase_chk.sv
module sdd_data_phase_chk
  import sdd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BLK_W = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [BLK_W-1:0] blocks_left,
  input logic [LVL_W-1:0] fifo_level,
  input logic             buf_wr_ready,
  input logic             card_ready,
  input logic [ST_W-1:0]  stat,
  input logic [EXP_W-1:0] tmo_exp,
  input logic             dreset
);
  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= DEPTH);

  p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_level) == DEPTH) |-> !card_ready || buf_wr_ready == 1'b0);

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (stat[ST_TC] || stat[ST_DTO] || $past(dreset)));

  p_blocks_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (blocks_left <= $past(blocks_left)));

  p_wr_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_ready |-> busy);

  p_dto_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_DTO]) |-> !busy);

  p_exp_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_exp <= EXP_MAX);

  p_wpe_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_WPE]) |-> !busy);

  p_dreset_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dreset |=> !busy);
endmodule

bind sdd_data_phase sdd_data_phase_chk #(.DEPTH(DEPTH), .BLK_W(BLK_W), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .blocks_left(blocks_left),
  .fifo_level(fifo_level), .buf_wr_ready(buf_wr_ready),
  .card_ready(card_ready), .stat(stat), .tmo_exp(tmo_exp), .dreset(dreset)
);

// File: tb/sdd_data_phase_tb_top.sv
module sdd_data_phase_tb_top;
  localparam int DEPTH = 16;
  localparam int BASE  = 2;

  logic        clk, rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        wp_locked, sd_clk_en, card_word, host_push, host_pop;
  logic        card_ready, busy, buf_rd_ready, buf_wr_ready;
  logic [15:0] blocks_left;
  logic [4:0]  fifo_level;
  logic [2:0]  stat;

  int n_chk = 0;
  int n_bad = 0;

  sdd_data_phase #(.DEPTH(DEPTH), .TMO_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wp_locked(wp_locked), .sd_clk_en(sd_clk_en),
    .card_word(card_word), .host_push(host_push), .host_pop(host_pop),
    .card_ready(card_ready), .busy(busy), .blocks_left(blocks_left),
    .fifo_level(fifo_level), .buf_rd_ready(buf_rd_ready),
    .buf_wr_ready(buf_wr_ready), .stat(stat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks below start and end at a falling edge
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic card1();
    card_word = 1'b1;
    @(negedge clk);
    card_word = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit go, input bit rd, input bit rst, input int e);
    return {12'd0, 4'(e), 13'd0, rst, rd, go};
  endfunction

  task automatic clear_all();
    wr(2'd2, ctrl(0, 0, 1, 14));
    cyc(1);
    wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 stat", stat, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 blocks_left", blocks_left, 0);
  endtask

  task automatic t_read();
    wr(2'd0, {16'd2, 16'd8});
    wr(2'd1, {16'd0, 16'd2});
    wr(2'd2, ctrl(1, 1, 0, 14));
    chk("R2 busy after read start", busy, 1);
    chk("R2 blocks_left at start", blocks_left, 2);
    card1();
    chk("R3 rd ready below mark", buf_rd_ready, 0);
    chk("R2 blocks_left mid block", blocks_left, 2);
    card1();
    chk("R3 rd ready at mark", buf_rd_ready, 1);
    chk("R2 blocks_left after block", blocks_left, 1);
    card1(); card1();
    chk("R2 busy after last block", busy, 0);
    chk("R2 tc flag", stat[0], 1);
    chk("R2 level kept", fifo_level, 4);
    host_pop = 1'b1; cyc(4); host_pop = 1'b0;
    chk("R3 rd ready empty", buf_rd_ready, 0);
    chk("R3 level drained", fifo_level, 0);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, {16'd0, 16'd8});
    wr(2'd2, ctrl(1, 1, 0, 14));
    chk("R2 zero count busy", busy, 0);
    chk("R2 zero count tc", stat[0], 1);
    wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_write();
    wr(2'd0, {16'd1, 16'd12});
    wr(2'd1, {16'd4, 16'd0});
    wr(2'd2, ctrl(1, 0, 0, 14));
    chk("R10 write empty card_ready", card_ready, 0);
    chk("R3 wr ready empty", buf_wr_ready, 1);
    host_push = 1'b1; cyc(13); host_push = 1'b0;
    chk("R3 level after push", fifo_level, 13);
    chk("R3 wr ready low space", buf_wr_ready, 0);
    card1(); card1();
    chk("R3 wr ready space back", buf_wr_ready, 1);
    chk("R2 write busy before last", busy, 1);
    card1();
    chk("R2 write done", busy, 0);
    chk("R2 write tc", stat[0], 1);
    chk("R2 write level", fifo_level, 10);
    wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_wp();
    wp_locked = 1'b1;
    wr(2'd0, {16'd1, 16'd4});
    wr(2'd2, ctrl(1, 0, 0, 14));
    chk("R7 locked write busy", busy, 0);
    chk("R7 refused flag", stat, 4);
    wr(2'd2, ctrl(1, 1, 0, 14));
    chk("R7 locked read runs", busy, 1);
    wp_locked = 1'b0;
    clear_all();
  endtask

  task automatic t_tmo(input int e);
    int lim = 1 << (e + BASE);
    wr(2'd0, {16'd1, 16'd4});
    wr(2'd2, ctrl(1, 1, 0, e));
    cyc(lim - 1);
    chk($sformatf("R4 no timeout e=%0d", e), stat[1], 0);
    chk($sformatf("R4 still busy e=%0d", e), busy, 1);
    cyc(1);
    chk($sformatf("R4 timeout e=%0d", e), stat[1], 1);
    chk($sformatf("R4 aborted e=%0d", e), busy, 0);
  endtask

  task automatic t_restart();
    wr(2'd0, {16'd4, 16'd4});
    wr(2'd2, ctrl(1, 1, 0, 1));
    cyc(6);
    card1();
    cyc(7);
    chk("R5 no timeout after restart", stat[1], 0);
    cyc(1);
    chk("R5 timeout after idle gap", stat[1], 1);
    clear_all();
  endtask

  task automatic t_clamp();
    wr(2'd0, {16'd1, 16'd4});
    wr(2'd2, ctrl(1, 1, 0, 15));
    cyc((1 << (14 + BASE)) - 1);
    chk("R6 clamp no timeout", stat[1], 0);
    cyc(1);
    chk("R6 clamp timeout at exp 14", stat[1], 1);
    clear_all();
  endtask

  task automatic t_w1c();
    wr(2'd0, {16'd0, 16'd4});
    wr(2'd2, ctrl(1, 1, 0, 14));
    t_tmo(0);
    chk("R8 both set", stat, 3);
    wr(2'd3, 32'h2);
    chk("R8 partial clear", stat, 1);
    wr(2'd3, 32'h0);
    chk("R8 zero write", stat, 1);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R8 all clear", stat, 0);
  endtask

  task automatic t_dreset();
    wr(2'd0, {16'd5, 16'd8});
    wr(2'd2, ctrl(1, 1, 0, 14));
    card1(); card1(); card1();
    chk("R9 pre level", fifo_level, 3);
    wr(2'd2, ctrl(1, 1, 1, 14));
    chk("R9 busy during reset cycle", busy, 1);
    cyc(1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 level cleared", fifo_level, 0);
    chk("R9 blocks cleared", blocks_left, 0);
    chk("R9 no flag", stat, 0);
  endtask

  task automatic t_flow();
    wr(2'd0, {16'd1, 16'd128});
    wr(2'd2, ctrl(1, 1, 0, 14));
    card_word = 1'b1; cyc(DEPTH); card_word = 1'b0;
    chk("R10 full level", fifo_level, DEPTH);
    chk("R10 full card_ready", card_ready, 0);
    card1();
    chk("R10 word refused", fifo_level, DEPTH);
    wr(2'd0, {16'd9, 16'd4});
    wr(2'd2, ctrl(1, 1, 0, 14));
    chk("R10 start while busy ignored", blocks_left, 1);
    host_pop = 1'b1; cyc(1); host_pop = 1'b0;
    chk("R10 ready after pop", card_ready, 1);
    clear_all();
  endtask

  initial begin
    int cnt = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    wp_locked = 1'b0; sd_clk_en = 1'b1; card_word = 1'b0;
    host_push = 1'b0; host_pop = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_read();
    t_write();
    t_wp();
    t_tmo(0);
    wr(2'd3, 32'hFFFF_FFFF);
    t_tmo(3);
    wr(2'd3, 32'hFFFF_FFFF);
    t_restart();
    t_clamp();
    t_w1c();
    t_dreset();
    t_flow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule